// File: doc/BRIEF.md
# Out-of-Order Issue Buffer

This block sits between instruction decode and a set of functional units. It keeps a small pool of decoded instructions: for each, a unit class, a destination register and two source registers. Decode hands in one instruction per cycle over a valid/ready pair. The buffer refuses an instruction when no slot is free. It also refuses one whose destination is still awaited by an earlier instruction, either buffered or already sent to a unit (write-after-write), and one whose destination is read by an instruction that is still buffered (write-after-read). Because of these checks, entries inside the buffer never have to be checked for name clashes among themselves.

Every cycle the buffer looks at all of its entries. An entry can leave when neither of its sources has a pending write, no older buffered entry writes either source, and its unit is not busy. Among the entries that can leave, the oldest one is dispatched, so an older instruction that is stuck does not hold back a younger one that is ready. A dispatched destination is marked pending until a write-back names that register. That write-back can then make waiting entries eligible.

Top module: `ooo_issue_buf`

## Requirements
- R1: After reset the buffer is empty, no register is pending, `dispValid` is low and `inReady` is high for any presented destination.
- R2: While all `DEPTH` slots hold instructions, `inReady` is low.
- R3: `inReady` is low when `inDest` equals the destination of any buffered entry, or a register that was dispatched and has not yet been written back (write-after-write).
- R4: `inReady` is low when `inDest` equals either source register of any buffered entry (write-after-read).
- R5: An entry is not dispatched while either of its source registers is pending, or while an older buffered entry has that register as its destination.
- R6: An entry is not dispatched while bit `unitBusy[unit]` is high for its unit class.
- R7: At most one entry is dispatched per cycle. When several entries are eligible, the one accepted earliest is chosen.
- R8: A younger eligible entry is dispatched while an older entry is blocked by R5 or R6.
- R9: A dispatched destination becomes pending from the next cycle on. A write-back (`wbValid`, `wbReg`) releases that register from the next cycle on, which can make waiting entries eligible.
- R10: Acceptance and eligibility use the state at the start of the cycle. An instruction accepted in cycle t can dispatch at t+1 at the earliest, and an entry that dispatches in cycle t still blocks acceptance in cycle t by R3 and R4.
- R11: A dispatch presents the unit class, destination and sources exactly as they were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Decode presents an instruction |
| inReady | output | 1 | Buffer accepts the presented instruction this cycle |
| inUnit | input | $clog2(NUNITS) | Unit class of the presented instruction |
| inDest | input | $clog2(NREGS) | Destination register |
| inSrcA | input | $clog2(NREGS) | First source register |
| inSrcB | input | $clog2(NREGS) | Second source register |
| unitBusy | input | NUNITS | One bit per unit class, high while that unit cannot take work |
| wbValid | input | 1 | A write-back completes this cycle |
| wbReg | input | $clog2(NREGS) | Register being written back |
| dispValid | output | 1 | An entry is dispatched this cycle |
| dispUnit | output | $clog2(NUNITS) | Unit class of the dispatched entry |
| dispDest | output | $clog2(NREGS) | Destination of the dispatched entry |
| dispSrcA | output | $clog2(NREGS) | First source of the dispatched entry |
| dispSrcB | output | $clog2(NREGS) | Second source of the dispatched entry |

## Verification
The assertions rely on three things about the environment. A write-back only names a register that was dispatched and is still pending. A unit that sees `dispValid` takes the instruction in that same cycle. `unitBusy` is stable between clock edges. The bench follows these rules by construction. Its behavioural unit model only returns registers it received through a dispatch, each after a latency of at least one cycle, and `unitBusy` and all decode inputs change only on the falling edge. Register numbers are drawn from a narrow range so that all three kinds of hazard come up often.

// File: rtl/ooo_issue_pkg.sv
package ooo_issue_pkg;
  // Width of the slot index carried in the strobe struct; bounds DEPTH to 256.
  localparam int SEL_W = 8;

  typedef struct packed {
    logic             doInsert;
    logic             doDispatch;
    logic [SEL_W-1:0] selIdx;
  } ctrl_strobe_t;
endpackage

// File: rtl/ooo_issue_slots.sv
// Datapath: age-ordered slot array (slot 0 oldest, kept compact) plus the
// pending-write vector for dispatched destinations.
module ooo_issue_slots #(
  parameter int DEPTH  = 4,
  parameter int NREGS  = 32,
  parameter int NUNITS = 4,
  localparam int REG_W  = $clog2(NREGS),
  localparam int UNIT_W = $clog2(NUNITS),
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  ooo_issue_pkg::ctrl_strobe_t       strb,
  input  logic [UNIT_W-1:0]                 inUnit,
  input  logic [REG_W-1:0]                  inDest,
  input  logic [REG_W-1:0]                  inSrcA,
  input  logic [REG_W-1:0]                  inSrcB,
  input  logic                              wbValid,
  input  logic [REG_W-1:0]                  wbReg,
  output logic [DEPTH-1:0]                  entValid,
  output logic [DEPTH-1:0][UNIT_W-1:0]      entUnit,
  output logic [DEPTH-1:0][REG_W-1:0]       entDest,
  output logic [DEPTH-1:0][REG_W-1:0]       entSrcA,
  output logic [DEPTH-1:0][REG_W-1:0]       entSrcB,
  output logic [NREGS-1:0]                  pendVec,
  output logic [UNIT_W-1:0]                 dispUnit,
  output logic [REG_W-1:0]                  dispDest,
  output logic [REG_W-1:0]                  dispSrcA,
  output logic [REG_W-1:0]                  dispSrcB
);

  logic [DEPTH-1:0]             validQ;
  logic [DEPTH-1:0][UNIT_W-1:0] unitQ;
  logic [DEPTH-1:0][REG_W-1:0]  destQ, srcAQ, srcBQ;
  logic [NREGS-1:0]             pendQ;

  logic [DEPTH-1:0]             shValid;
  logic [DEPTH-1:0][UNIT_W-1:0] shUnit;
  logic [DEPTH-1:0][REG_W-1:0]  shDest, shSrcA, shSrcB;

  logic [DEPTH-1:0]             nxValid;
  logic [DEPTH-1:0][UNIT_W-1:0] nxUnit;
  logic [DEPTH-1:0][REG_W-1:0]  nxDest, nxSrcA, nxSrcB;
  logic [NREGS-1:0]             pendNx;

  logic [IDX_W-1:0]             selSlot;
  assign selSlot = strb.selIdx[IDX_W-1:0];

  // Removal of the dispatched slot: every slot at or above it takes its upper
  // neighbour, so age order is kept by position.
  for (genvar g = 0; g < DEPTH; g++) begin : g_shift
    logic takeUp;
    assign takeUp = strb.doDispatch && (g >= int'(strb.selIdx));
    if (g < DEPTH - 1) begin : g_mid
      assign shValid[g] = takeUp ? validQ[g+1] : validQ[g];
      assign shUnit[g]  = takeUp ? unitQ[g+1]  : unitQ[g];
      assign shDest[g]  = takeUp ? destQ[g+1]  : destQ[g];
      assign shSrcA[g]  = takeUp ? srcAQ[g+1]  : srcAQ[g];
      assign shSrcB[g]  = takeUp ? srcBQ[g+1]  : srcBQ[g];
    end else begin : g_top
      assign shValid[g] = takeUp ? 1'b0 : validQ[g];
      assign shUnit[g]  = unitQ[g];
      assign shDest[g]  = destQ[g];
      assign shSrcA[g]  = srcAQ[g];
      assign shSrcB[g]  = srcBQ[g];
    end
  end

  // New instruction lands in the lowest free slot after the shift.
  always_comb begin
    logic placed;
    nxValid = shValid;
    nxUnit  = shUnit;
    nxDest  = shDest;
    nxSrcA  = shSrcA;
    nxSrcB  = shSrcB;
    placed  = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (strb.doInsert && !placed && !shValid[i]) begin
        nxValid[i] = 1'b1;
        nxUnit[i]  = inUnit;
        nxDest[i]  = inDest;
        nxSrcA[i]  = inSrcA;
        nxSrcB[i]  = inSrcB;
        placed     = 1'b1;
      end
    end
  end

  // Pending writes: write-back releases, dispatch claims (claim wins).
  always_comb begin
    pendNx = pendQ;
    if (wbValid) pendNx[wbReg] = 1'b0;
    if (strb.doDispatch) pendNx[destQ[selSlot]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      validQ <= '0;
      unitQ  <= '0;
      destQ  <= '0;
      srcAQ  <= '0;
      srcBQ  <= '0;
      pendQ  <= '0;
    end else begin
      validQ <= nxValid;
      unitQ  <= nxUnit;
      destQ  <= nxDest;
      srcAQ  <= nxSrcA;
      srcBQ  <= nxSrcB;
      pendQ  <= pendNx;
    end
  end

  assign entValid = validQ;
  assign entUnit  = unitQ;
  assign entDest  = destQ;
  assign entSrcA  = srcAQ;
  assign entSrcB  = srcBQ;
  assign pendVec  = pendQ;

  assign dispUnit = unitQ[selSlot];
  assign dispDest = destQ[selSlot];
  assign dispSrcA = srcAQ[selSlot];
  assign dispSrcB = srcBQ[selSlot];

endmodule

// File: rtl/ooo_issue_ctrl.sv
// Control: insertion hazard filter and oldest-eligible select.
module ooo_issue_ctrl #(
  parameter int DEPTH  = 4,
  parameter int NREGS  = 32,
  parameter int NUNITS = 4,
  localparam int REG_W  = $clog2(NREGS),
  localparam int UNIT_W = $clog2(NUNITS)
) (
  input  logic                              inValid,
  input  logic [REG_W-1:0]                  inDest,
  input  logic [DEPTH-1:0]                  entValid,
  input  logic [DEPTH-1:0][UNIT_W-1:0]      entUnit,
  input  logic [DEPTH-1:0][REG_W-1:0]       entDest,
  input  logic [DEPTH-1:0][REG_W-1:0]       entSrcA,
  input  logic [DEPTH-1:0][REG_W-1:0]       entSrcB,
  input  logic [NREGS-1:0]                  pendVec,
  input  logic [NUNITS-1:0]                 unitBusy,
  output logic                              inReady,
  output logic                              dispValid,
  output ooo_issue_pkg::ctrl_strobe_t       strb
);
  import ooo_issue_pkg::*;

  logic             slotsFull;
  logic             nameClash;
  logic [DEPTH-1:0] eligible;
  logic             found;
  logic [SEL_W-1:0] pick;

  assign slotsFull = &entValid;

  // Write-after-write against buffered and in-flight destinations,
  // write-after-read against buffered sources.
  always_comb begin
    nameClash = pendVec[inDest];
    for (int j = 0; j < DEPTH; j++) begin
      if (entValid[j] && (entDest[j] == inDest || entSrcA[j] == inDest ||
                          entSrcB[j] == inDest))
        nameClash = 1'b1;
    end
  end

  assign inReady = !slotsFull && !nameClash;

  // Readiness is re-evaluated for every slot each cycle.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      eligible[i] = entValid[i] && !pendVec[entSrcA[i]] &&
                    !pendVec[entSrcB[i]] && !unitBusy[entUnit[i]];
      for (int j = 0; j < DEPTH; j++) begin
        if (j < i && entValid[j] &&
            (entDest[j] == entSrcA[i] || entDest[j] == entSrcB[i]))
          eligible[i] = 1'b0;
      end
    end
  end

  // Lowest position is the oldest entry.
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (eligible[i] && !found) begin
        found = 1'b1;
        pick  = SEL_W'(i);
      end
    end
  end

  assign dispValid       = found;
  assign strb.doInsert   = inValid && inReady;
  assign strb.doDispatch = found;
  assign strb.selIdx     = pick;

endmodule

// File: rtl/ooo_issue_buf.sv
module ooo_issue_buf #(
  parameter int DEPTH  = 4,
  parameter int NREGS  = 32,
  parameter int NUNITS = 4,
  localparam int REG_W  = $clog2(NREGS),
  localparam int UNIT_W = $clog2(NUNITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  output logic              inReady,
  input  logic [UNIT_W-1:0] inUnit,
  input  logic [REG_W-1:0]  inDest,
  input  logic [REG_W-1:0]  inSrcA,
  input  logic [REG_W-1:0]  inSrcB,
  input  logic [NUNITS-1:0] unitBusy,
  input  logic              wbValid,
  input  logic [REG_W-1:0]  wbReg,
  output logic              dispValid,
  output logic [UNIT_W-1:0] dispUnit,
  output logic [REG_W-1:0]  dispDest,
  output logic [REG_W-1:0]  dispSrcA,
  output logic [REG_W-1:0]  dispSrcB
);

  ooo_issue_pkg::ctrl_strobe_t  strb;
  logic [DEPTH-1:0]             entValid;
  logic [DEPTH-1:0][UNIT_W-1:0] entUnit;
  logic [DEPTH-1:0][REG_W-1:0]  entDest, entSrcA, entSrcB;
  logic [NREGS-1:0]             pendVec;

  ooo_issue_ctrl #(.DEPTH(DEPTH), .NREGS(NREGS), .NUNITS(NUNITS)) ctrl_i (
    .inValid  (inValid),
    .inDest   (inDest),
    .entValid (entValid),
    .entUnit  (entUnit),
    .entDest  (entDest),
    .entSrcA  (entSrcA),
    .entSrcB  (entSrcB),
    .pendVec  (pendVec),
    .unitBusy (unitBusy),
    .inReady  (inReady),
    .dispValid(dispValid),
    .strb     (strb)
  );

  ooo_issue_slots #(.DEPTH(DEPTH), .NREGS(NREGS), .NUNITS(NUNITS)) slots_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .inUnit  (inUnit),
    .inDest  (inDest),
    .inSrcA  (inSrcA),
    .inSrcB  (inSrcB),
    .wbValid (wbValid),
    .wbReg   (wbReg),
    .entValid(entValid),
    .entUnit (entUnit),
    .entDest (entDest),
    .entSrcA (entSrcA),
    .entSrcB (entSrcB),
    .pendVec (pendVec),
    .dispUnit(dispUnit),
    .dispDest(dispDest),
    .dispSrcA(dispSrcA),
    .dispSrcB(dispSrcB)
  );

endmodule

// File: rtl/ooo_issue_chk.sv
module ooo_issue_chk #(
  parameter int DEPTH  = 4,
  parameter int NREGS  = 32,
  parameter int NUNITS = 4,
  localparam int REG_W  = $clog2(NREGS),
  localparam int UNIT_W = $clog2(NUNITS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inValid,
  input logic              inReady,
  input logic [NUNITS-1:0] unitBusy,
  input logic              wbValid,
  input logic [REG_W-1:0]  wbReg,
  input logic              dispValid,
  input logic [UNIT_W-1:0] dispUnit,
  input logic [REG_W-1:0]  dispDest,
  input logic [REG_W-1:0]  dispSrcA,
  input logic [REG_W-1:0]  dispSrcB,
  input logic [DEPTH-1:0]  entValid,
  input logic [NREGS-1:0]  pendVec
);

  AST_DISP_UNIT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    dispValid |-> !unitBusy[dispUnit]); // R6

  AST_DISP_SRC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    dispValid |-> (!pendVec[dispSrcA] && !pendVec[dispSrcB])); // R5

  AST_DISP_MARKS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    dispValid |=> pendVec[$past(dispDest)]); // R9

  AST_WB_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (wbValid && !(dispValid && dispDest == wbReg)) |=> !pendVec[$past(wbReg)]); // R9

  AST_NO_ACCEPT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (&entValid) |-> !inReady); // R2

  AST_SLOTS_COMPACT: assert property (@(posedge clk) disable iff (!rst_n)
    ((entValid & (entValid + 1'b1)) == '0)); // R7

  AST_OCCUPANCY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> int'($countones(entValid)) ==
              int'($past($countones(entValid))) + int'($past(inValid && inReady)) -
              int'($past(dispValid))); // R7

endmodule

bind ooo_issue_buf ooo_issue_chk #(.DEPTH(DEPTH), .NREGS(NREGS), .NUNITS(NUNITS)) chk_i (.*);

// File: tb/ooo_issue_buf_tb.sv
module ooo_issue_buf_tb_top;
  localparam int DEPTH  = 4;
  localparam int NREGS  = 32;
  localparam int NUNITS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [1:0] inUnit = '0;
  logic [4:0] inDest = '0, inSrcA = '0, inSrcB = '0;
  logic [3:0] unitBusy = '0;
  logic       wbValid = 1'b0;
  logic [4:0] wbReg = '0;
  logic       dispValid;
  logic [1:0] dispUnit;
  logic [4:0] dispDest, dispSrcA, dispSrcB;

  always #4 clk = ~clk;

  ooo_issue_buf #(.DEPTH(DEPTH), .NREGS(NREGS), .NUNITS(NUNITS)) dut_i (.*);

  int checks = 0;
  int fails  = 0;

  // Reference state: age-ordered queues, pending bits, unit model.
  int qU[$], qD[$], qA[$], qB[$];
  bit pend[NREGS];
  int fDest[$], fLeft[$];
  int curLat = 2;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit v, input int u, input int d,
                      input int a, input int b, input int busy);
    int wbIdx;
    bit expRdy;
    int sel;
    @(negedge clk);
    wbIdx = -1;
    foreach (fLeft[k]) if (wbIdx < 0 && fLeft[k] <= 0) wbIdx = k;
    wbValid  = (wbIdx >= 0);
    wbReg    = (wbIdx >= 0) ? 5'(fDest[wbIdx]) : 5'd0;
    inValid  = v;
    inUnit   = 2'(u);
    inDest   = 5'(d);
    inSrcA   = 5'(a);
    inSrcB   = 5'(b);
    unitBusy = 4'(busy);
    #1;
    // acceptance rule
    expRdy = (qD.size() < DEPTH) && !pend[d];
    foreach (qD[k]) if (qD[k] == d || qA[k] == d || qB[k] == d) expRdy = 0;
    // dispatch rule
    sel = -1;
    foreach (qD[k]) begin
      bit ok;
      ok = !pend[qA[k]] && !pend[qB[k]] && !busy[qU[k]];
      for (int j = 0; j < k; j++) if (qD[j] == qA[k] || qD[j] == qB[k]) ok = 0;
      if (ok && sel < 0) sel = k;
    end
    check(tag, "inReady", int'(inReady), int'(expRdy));
    check(tag, "dispValid", int'(dispValid), int'(sel >= 0));
    if (sel >= 0 && dispValid) begin
      check("R11", "dispUnit", int'(dispUnit), qU[sel]);
      check("R11", "dispDest", int'(dispDest), qD[sel]);
      check("R11", "dispSrcA", int'(dispSrcA), qA[sel]);
      check("R11", "dispSrcB", int'(dispSrcB), qB[sel]);
    end
    // advance the reference state
    if (wbIdx >= 0) begin
      pend[fDest[wbIdx]] = 0;
      fDest.delete(wbIdx);
      fLeft.delete(wbIdx);
    end
    foreach (fLeft[k]) fLeft[k] = fLeft[k] - 1;
    if (sel >= 0) begin
      pend[qD[sel]] = 1;
      fDest.push_back(qD[sel]);
      fLeft.push_back(curLat);
      qU.delete(sel); qD.delete(sel); qA.delete(sel); qB.delete(sel);
    end
    if (v && expRdy) begin
      qU.push_back(u); qD.push_back(d); qA.push_back(a); qB.push_back(b);
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: empty after reset
    step("R1", 0, 0, 5, 5, 5, 0);
    step("R1", 1, 0, 31, 30, 29, 15);     // accepted while units busy
    step("R1", 0, 0, 0, 0, 0, 0);         // it dispatches now
    repeat (4) step("R9", 0, 0, 0, 0, 0, 0);
    // R6 + R8: older entry on a busy unit, younger one overtakes
    step("R6", 1, 0, 1, 2, 3, 4'b0001);
    step("R8", 1, 1, 4, 5, 6, 4'b0001);
    step("R8", 0, 0, 0, 0, 0, 4'b0001);
    // R3 / R9: destination 4 now in flight
    step("R3", 1, 2, 4, 7, 7, 4'b0001);
    // R7: oldest dispatches; new entry reads reg 1 (no clash on its dest)
    step("R7", 1, 2, 9, 1, 8, 4'b0000);
    // R5: reg 1 pending
    step("R5", 0, 0, 0, 0, 0, 4'b0000);
    // R4: dest 8 is read by a buffered entry
    step("R4", 1, 3, 8, 0, 0, 4'b1111);
    // R3: dest 9 is written by a buffered entry
    step("R3", 1, 3, 9, 0, 0, 4'b1111);
    repeat (6) step("R9", 0, 0, 0, 0, 0, 4'b0000);
    // R2: fill every slot while all units are busy
    for (int k = 0; k < DEPTH; k++)
      step("R2", 1, k % NUNITS, 10 + k, 20 + 2 * k, 21 + 2 * k, 4'b1111);
    step("R2", 1, 0, 14, 0, 0, 4'b1111);
    step("R7", 0, 0, 0, 0, 0, 4'b0000);
    // R10: slot with source 22 dispatches this cycle yet still blocks dest 22
    step("R10", 1, 0, 22, 0, 0, 4'b0000);
    step("R10", 1, 1, 15, 13, 13, 4'b1111);
    repeat (10) step("R9", 0, 0, 0, 0, 0, 4'b0000);
    // mixed traffic over a narrow register range
    for (int n = 0; n < 4000; n++) begin
      curLat = 1 + int'($urandom_range(0, 4));
      step("R5 R6 R7 R8", $urandom_range(0, 9) < 7, int'($urandom_range(0, 3)),
           int'($urandom_range(0, 11)), int'($urandom_range(0, 11)),
           int'($urandom_range(0, 11)),
           int'($urandom_range(0, 15) & $urandom_range(0, 15)));
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule